// File: doc/BRIEF.md
# Prioritized ADC Sample Sequencer

This block schedules work for a single analog-to-digital converter shared by four sample sequencers. Each sequencer owns a short program of steps. Every step names an input channel and carries a 4-bit control nibble. A sequencer watches one event line, chosen by a per-sequencer select field. When that line is high while the sequencer is enabled, a request is latched as pending.

Whenever the converter is free and at least one enabled sequencer is pending, a programmable priority arbiter picks one sequencer. That sequencer then runs its steps in order to completion. For each step the block issues a one-cycle start pulse with the channel number, waits for the converter's done pulse, and stores the returned sample in that sequencer's result register. A step whose control nibble requests it sets the sequencer's raw interrupt bit. A mask register gates the raw bits onto the interrupt outputs.

Software configures everything through a flat word-addressed register port with a combinational read. Reset is synchronous and active-low.

Top module: `adc_seq_sched`

## Requirements
- R1: After reset, the enable, mask and raw status registers read 0, the priority register reads 0xE4, every interrupt output is 0 and no start pulse is issued.
- R2: A disabled sequencer never starts a conversion, whatever its event line does. Its channel list (0x20+0x10*s), control word (0x24+0x10*s), event select (0x10) and the enable register (0x00, bit s) can be written and read back while it is disabled.
- R3: Sequencer s becomes pending when its select field (register 0x10, bits 4s+3..4s) names an event input that is high while bit s of 0x00 is set. A select value at or above the number of event inputs never triggers.
- R4: Step k of a running sequencer issues a conv_start pulse exactly one cycle long, with conv_chan equal to bits 4k+3..4k of that sequencer's channel list. Steps are issued in increasing k, one per converter done pulse.
- R5: Control nibble k sits at bits 4k+3..4k of the control word. When its bit 1 (end) is set, the sequence finishes after step k.
- R6: If no end bit is met, the sequence finishes after its last physical step: step 7 for sequencer 0, step 3 for sequencers 1 and 2, and step 0 for sequencer 3.
- R7: Among pending enabled sequencers, the one whose 2-bit level in register 0x14 (bits 2s+1..2s) is numerically lowest starts next. On equal levels the lower index wins. The reset value 0xE4 orders 0 before 1 before 2 before 3.
- R8: A running sequence is never interrupted. An event that arrives for any sequencer while one is running stays pending and is served after the running sequence ends, including a repeat event for the running sequencer itself.
- R9: Each converter done pulse stores conv_data in the running sequencer's result register (0x28+0x10*s, read-only). The other result registers stay unchanged.
- R10: A completed step whose control bit 2 is set sets raw status bit s (register 0x04, read-only). Writing 1 to bit s of register 0x0C clears it. Register 0x0C reads 0.
- R11: Each interrupt output bit s equals raw bit s AND mask bit s (register 0x08).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte address |
| rd_data | output | 32 | Register read data (combinational) |
| evt_in | input | NUM_EVT | Trigger event lines |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 4 | Channel for the current request |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | RES_W | Sample returned with conv_done |
| irq | output | 4 | Masked per-sequencer interrupts |

## Verification
The bench drives two sequencers with events in the same cycle, first under the default order, then with the order inverted, then with all levels equal. A swapped comparison or a wrong tie-break shows up as channels arriving in the wrong order. It also re-triggers the running sequencer mid-sequence while a higher-level sequencer is pending. A design that preempted would splice foreign channels into the middle of the running list, and one that dropped busy-time events would run the repeat zero times. Sequences with no end bit on sequencers 0, 1 and 3 catch a wrong physical-depth limit as a wrong number of start pulses. Out-of-range event selects and disabled sequencers must produce no start pulse at all.

// File: rtl/adc_seq_pkg.sv
// adc_seq_pkg: shared constants, register offsets, types and the
// per-sequencer depth function for the ADC sample sequencer.
// Assumes exactly four sequencers with 4-bit channel and control nibbles.
package adc_seq_pkg;
    localparam int NSEQ      = 4;
    localparam int SEQ_IDX_W = $clog2(NSEQ);
    localparam int STEPS_MAX = 8;
    localparam int STEP_W    = $clog2(STEPS_MAX);
    localparam int CHAN_W    = 4;
    localparam int NIB_W     = 4;
    localparam int SEL_W     = 4;
    localparam int PRIO_W    = 2;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;

    localparam int DEPTH_SEQ0  = 8;
    localparam int DEPTH_SEQ3  = 1;
    localparam int DEPTH_OTHER = 4;

    localparam int NIB_END = 1;
    localparam int NIB_IE  = 2;

    localparam logic [ADDR_W-1:0] A_ENABLE   = 8'h00;
    localparam logic [ADDR_W-1:0] A_RAW      = 8'h04;
    localparam logic [ADDR_W-1:0] A_MASK     = 8'h08;
    localparam logic [ADDR_W-1:0] A_CLEAR    = 8'h0C;
    localparam logic [ADDR_W-1:0] A_EVSEL    = 8'h10;
    localparam logic [ADDR_W-1:0] A_PRIO     = 8'h14;
    localparam int                SEQ_BASE   = 'h20;
    localparam int                SEQ_STRIDE = 'h10;
    localparam int                OFS_MUX    = 'h0;
    localparam int                OFS_CTL    = 'h4;
    localparam int                OFS_RES    = 'h8;

    typedef logic [NSEQ-1:0][DATA_W-1:0] seq_words_t;
    typedef logic [NSEQ-1:0][SEL_W-1:0]  sel_vec_t;
    typedef logic [NSEQ-1:0][PRIO_W-1:0] prio_vec_t;

    typedef enum logic [1:0] {ST_IDLE, ST_START, ST_WAIT} eng_state_t;

    // Number of physical steps a sequencer owns.
    function automatic int seq_depth(int s);
        case (s)
            0:       return DEPTH_SEQ0;
            3:       return DEPTH_SEQ3;
            default: return DEPTH_OTHER;
        endcase
    endfunction

    // Reset priority levels: sequencer s gets level s.
    function automatic prio_vec_t prio_default();
        prio_vec_t p;
        for (int s = 0; s < NSEQ; s++) p[s] = PRIO_W'(s);
        return p;
    endfunction

    // Byte address of a per-sequencer register.
    function automatic logic [ADDR_W-1:0] seq_addr(int s, int ofs);
        return ADDR_W'(SEQ_BASE + s * SEQ_STRIDE + ofs);
    endfunction
endpackage

// File: rtl/adc_seq_arb.sv
// adc_seq_arb: combinational priority arbiter over the pending sequencers.
// Lowest level value wins; on equal levels the lower index wins.
// Assumes req_i is already qualified by the enable bits.
module adc_seq_arb
    import adc_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSEQ-1:0]      req_i,
    input  prio_vec_t            prio_i,
    output logic [NSEQ-1:0]      grant_o,
    output logic [SEQ_IDX_W-1:0] idx_o,
    output logic                 vld_o
);
    genvar gi, gj;
    generate
        for (gi = 0; gi < NSEQ; gi++) begin : g_cand
            logic [NSEQ-1:0] beats;
            for (gj = 0; gj < NSEQ; gj++) begin : g_rival
                if (gj == gi) begin : g_self
                    assign beats[gj] = 1'b1;
                end else if (gj < gi) begin : g_lower
                    assign beats[gj] = !req_i[gj] || (prio_i[gi] < prio_i[gj]);
                end else begin : g_higher
                    assign beats[gj] = !req_i[gj] || (prio_i[gi] <= prio_i[gj]);
                end
            end
            assign grant_o[gi] = req_i[gi] & (&beats);
        end
    endgenerate

    // Encode the one-hot grant into an index.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NSEQ; i++)
            if (grant_o[i]) idx_o = SEQ_IDX_W'(i);
    end

    assign vld_o = |req_i;

    assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    assert_grant_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0);
    assert_grant_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |-> (|grant_o));
endmodule

// File: rtl/adc_seq_engine.sv
// adc_seq_engine: latches per-sequencer trigger events, picks a sequencer
// through the arbiter and walks its steps against the converter handshake.
// Assumes conv_done arrives no earlier than the cycle after conv_start.
module adc_seq_engine
    import adc_seq_pkg::*;
#(
    parameter int NUM_EVT = 4,
    parameter int RES_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSEQ-1:0]    en_i,
    input  sel_vec_t           evsel_i,
    input  prio_vec_t          prio_i,
    input  seq_words_t         mux_i,
    input  seq_words_t         ctl_i,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               conv_start_o,
    output logic [CHAN_W-1:0]  conv_chan_o,
    input  logic               conv_done_i,
    input  logic [RES_W-1:0]   conv_data_i,
    output logic [NSEQ-1:0]    raw_set_o,
    output logic [NSEQ-1:0]    res_we_o,
    output logic [RES_W-1:0]   res_data_o
);
    localparam int EXT_W = 2 ** SEL_W;

    logic [EXT_W-1:0]     evt_ext;
    logic [NSEQ-1:0]      hit, pend_q, req, grant;
    logic [SEQ_IDX_W-1:0] grant_idx, cur_q;
    logic                 grant_vld, launch, fin, last_step;
    eng_state_t           state_q;
    logic [STEP_W-1:0]    step_q;
    logic [DATA_W-1:0]    cur_mux, cur_ctl;
    logic [NIB_W-1:0]     cur_nib;

    assign evt_ext = EXT_W'(evt_i);

    genvar gs;
    generate
        for (gs = 0; gs < NSEQ; gs++) begin : g_hit
            assign hit[gs] = en_i[gs] & evt_ext[evsel_i[gs]];
        end
    endgenerate

    assign req = pend_q & en_i;

    adc_seq_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .prio_i  (prio_i),
        .grant_o (grant),
        .idx_o   (grant_idx),
        .vld_o   (grant_vld)
    );

    assign cur_mux   = mux_i[cur_q];
    assign cur_ctl   = ctl_i[cur_q];
    assign cur_nib   = cur_ctl[step_q*NIB_W +: NIB_W];
    assign last_step = cur_nib[NIB_END] || (int'(step_q) == seq_depth(int'(cur_q)) - 1);
    assign launch    = (state_q == ST_IDLE) && grant_vld;
    assign fin       = (state_q == ST_WAIT) && conv_done_i;

    // Pending events: set by a hit, cleared on launch, dropped when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= ((pend_q & ~(launch ? grant : '0)) | hit) & en_i;
    end

    // Step walker: launch, issue start, wait for done, advance or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            step_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (launch) begin
                    cur_q   <= grant_idx;
                    step_q  <= '0;
                    state_q <= ST_START;
                end
                ST_START: state_q <= ST_WAIT;
                ST_WAIT: if (fin) begin
                    if (last_step) state_q <= ST_IDLE;
                    else begin
                        step_q  <= step_q + STEP_W'(1);
                        state_q <= ST_START;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Converter request and completion outputs.
    assign conv_start_o = (state_q == ST_START);
    assign conv_chan_o  = cur_mux[step_q*CHAN_W +: CHAN_W];
    assign res_we_o     = fin ? (NSEQ'(1) << cur_q) : '0;
    assign raw_set_o    = (fin && cur_nib[NIB_IE]) ? (NSEQ'(1) << cur_q) : '0;
    assign res_data_o   = conv_data_i;

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);
    assert_no_preempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !conv_done_i) |=> (state_q == ST_WAIT && $stable(cur_q) && $stable(step_q)));
    assert_step_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (int'(step_q) < seq_depth(int'(cur_q))));
    assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_q & ~$past(en_i)) == '0));
endmodule

// File: rtl/adc_seq_regs.sv
// adc_seq_regs: configuration, status, mask and result registers with a
// combinational read port and the masked interrupt outputs.
// Assumes writes and result updates come from the same clock domain.
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NSEQ-1:0]   en_o,
    output sel_vec_t          evsel_o,
    output prio_vec_t         prio_o,
    output seq_words_t        mux_o,
    output seq_words_t        ctl_o,
    input  logic [NSEQ-1:0]   raw_set_i,
    input  logic [NSEQ-1:0]   res_we_i,
    input  logic [RES_W-1:0]  res_data_i,
    output logic [NSEQ-1:0]   irq_o
);
    logic [NSEQ-1:0]            en_q, mask_q, raw_q, clr_bits;
    sel_vec_t                   evsel_q;
    prio_vec_t                  prio_q;
    seq_words_t                 mux_q, ctl_q;
    logic [NSEQ-1:0][RES_W-1:0] res_q;

    assign clr_bits = (wr_en && wr_addr == A_CLEAR) ? wr_data[NSEQ-1:0] : '0;

    // Global registers and raw status (a set wins over a clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            mask_q  <= '0;
            raw_q   <= '0;
            evsel_q <= '0;
            prio_q  <= prio_default();
        end else begin
            if (wr_en && wr_addr == A_ENABLE) en_q    <= wr_data[NSEQ-1:0];
            if (wr_en && wr_addr == A_MASK)   mask_q  <= wr_data[NSEQ-1:0];
            if (wr_en && wr_addr == A_EVSEL)  evsel_q <= wr_data[NSEQ*SEL_W-1:0];
            if (wr_en && wr_addr == A_PRIO)   prio_q  <= wr_data[NSEQ*PRIO_W-1:0];
            raw_q <= (raw_q & ~clr_bits) | raw_set_i;
        end
    end

    genvar gs;
    generate
        for (gs = 0; gs < NSEQ; gs++) begin : g_seq
            // Per-sequencer channel list, control word and result.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mux_q[gs] <= '0;
                    ctl_q[gs] <= '0;
                    res_q[gs] <= '0;
                end else begin
                    if (wr_en && wr_addr == seq_addr(gs, OFS_MUX)) mux_q[gs] <= wr_data;
                    if (wr_en && wr_addr == seq_addr(gs, OFS_CTL)) ctl_q[gs] <= wr_data;
                    if (res_we_i[gs]) res_q[gs] <= res_data_i;
                end
            end

            assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !res_we_i[gs] |=> $stable(res_q[gs]));
        end
    endgenerate

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_ENABLE: rd_data = DATA_W'(en_q);
            A_RAW:    rd_data = DATA_W'(raw_q);
            A_MASK:   rd_data = DATA_W'(mask_q);
            A_EVSEL:  rd_data = DATA_W'(evsel_q);
            A_PRIO:   rd_data = DATA_W'(prio_q);
            default: begin
                for (int s = 0; s < NSEQ; s++) begin
                    if (rd_addr == seq_addr(s, OFS_MUX)) rd_data = mux_q[s];
                    if (rd_addr == seq_addr(s, OFS_CTL)) rd_data = ctl_q[s];
                    if (rd_addr == seq_addr(s, OFS_RES)) rd_data = DATA_W'(res_q[s]);
                end
            end
        endcase
    end

    assign en_o    = en_q;
    assign evsel_o = evsel_q;
    assign prio_o  = prio_q;
    assign mux_o   = mux_q;
    assign ctl_o   = ctl_q;
    assign irq_o   = raw_q & mask_q;

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CLEAR) |=> ((raw_q & $past(wr_data[NSEQ-1:0] & ~raw_set_i)) == '0));
    assert_raw_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((raw_q & ~$past(raw_q) & ~$past(raw_set_i)) == '0));
endmodule

// File: rtl/adc_seq_sched.sv
// adc_seq_sched: top of the prioritized four-sequencer ADC scheduler.
// Joins the register block and the step engine; the converter sits outside.
// Assumes a converter that answers each start with exactly one done pulse.
module adc_seq_sched
    import adc_seq_pkg::*;
#(
    parameter int NUM_EVT = 4,
    parameter int RES_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [7:0]         rd_addr,
    output logic [31:0]        rd_data,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               conv_start,
    output logic [3:0]         conv_chan,
    input  logic               conv_done,
    input  logic [RES_W-1:0]   conv_data,
    output logic [3:0]         irq
);
    logic [NSEQ-1:0]  en, raw_set, res_we;
    sel_vec_t         evsel;
    prio_vec_t        prio;
    seq_words_t       mux, ctl;
    logic [RES_W-1:0] res_data;

    adc_seq_regs #(.RES_W(RES_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .en_o       (en),
        .evsel_o    (evsel),
        .prio_o     (prio),
        .mux_o      (mux),
        .ctl_o      (ctl),
        .raw_set_i  (raw_set),
        .res_we_i   (res_we),
        .res_data_i (res_data),
        .irq_o      (irq)
    );

    adc_seq_engine #(.NUM_EVT(NUM_EVT), .RES_W(RES_W)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .evsel_i      (evsel),
        .prio_i       (prio),
        .mux_i        (mux),
        .ctl_i        (ctl),
        .evt_i        (evt_in),
        .conv_start_o (conv_start),
        .conv_chan_o  (conv_chan),
        .conv_done_i  (conv_done),
        .conv_data_i  (conv_data),
        .raw_set_o    (raw_set),
        .res_we_o     (res_we),
        .res_data_o   (res_data)
    );
endmodule

// File: tb/adc_seq_sched_tb.sv
// adc_seq_sched_tb: behavioural reference model compared every clock,
// plus directed scenarios with hand-computed channel orders.
module adc_seq_sched_tb;
    localparam int NUM_EVT = 4;
    localparam int RES_W   = 10;
    localparam int LAT     = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [7:0]        rd_addr = '0;
    logic [31:0]       rd_data;
    logic [NUM_EVT-1:0] evt_in = '0;
    logic              conv_start;
    logic [3:0]        conv_chan;
    logic              conv_done = 1'b0;
    logic [RES_W-1:0]  conv_data = '0;
    logic [3:0]        irq;

    always #10 clk = ~clk;

    adc_seq_sched #(.NUM_EVT(NUM_EVT), .RES_W(RES_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_in(evt_in), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_data(conv_data), .irq(irq)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    logic [3:0] chan_log[$];
    int conv_cnt = 0;
    logic [3:0] conv_last = '0;
    int rot = 0;

    // Reference model state.
    logic [3:0]  m_en, m_mask, m_raw, m_pend;
    logic [15:0] m_evsel;
    logic [7:0]  m_prio;
    logic [31:0] m_mux[4];
    logic [31:0] m_ctl[4];
    logic [31:0] m_res[4];
    int m_state, m_cur, m_step;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(logic [7:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            8'h00: r = {28'd0, m_en};
            8'h04: r = {28'd0, m_raw};
            8'h08: r = {28'd0, m_mask};
            8'h10: r = {16'd0, m_evsel};
            8'h14: r = {24'd0, m_prio};
            default: for (int s = 0; s < 4; s++) begin
                if (a == 8'(32 + 16*s))     r = m_mux[s];
                if (a == 8'(32 + 16*s + 4)) r = m_ctl[s];
                if (a == 8'(32 + 16*s + 8)) r = m_res[s];
            end
        endcase
        return r;
    endfunction

    function automatic string rtag(logic [7:0] a);
        if (a == 8'h04) return "R10 raw status";
        if (a == 8'h14) return "R7 priority";
        if (a == 8'h10) return "R3 event select";
        if (a >= 8'h20 && a[3:0] == 4'h8) return "R9 result";
        return "R2 config readback";
    endfunction

    function automatic logic [7:0] rot_addr(int i);
        int j;
        if (i < 6) return 8'(i * 4);
        j = i - 6;
        return 8'(32 + (j / 3) * 16 + (j % 3) * 4);
    endfunction

    // Reference model: one update per rising edge from pre-edge values.
    always @(posedge clk) begin
        logic [3:0] hit, req, clr, setb, clrw, n_pend;
        int win, n_state, n_cur, n_step, dep;
        logic [3:0] nib;
        if (!rst_n) begin
            m_en = 0; m_mask = 0; m_raw = 0; m_pend = 0;
            m_evsel = 0; m_prio = 8'hE4;
            for (int s = 0; s < 4; s++) begin m_mux[s] = 0; m_ctl[s] = 0; m_res[s] = 0; end
            m_state = 0; m_cur = 0; m_step = 0;
        end else begin
            hit = 0; clr = 0; setb = 0;
            for (int s = 0; s < 4; s++) begin
                int sel;
                sel = int'(m_evsel[4*s +: 4]);
                if (m_en[s] && sel < NUM_EVT && evt_in[sel]) hit[s] = 1;
            end
            req = m_pend & m_en;
            n_state = m_state; n_cur = m_cur; n_step = m_step;
            if (m_state == 0) begin
                win = -1;
                for (int s = 0; s < 4; s++)
                    if (req[s] && (win < 0 || m_prio[2*s +: 2] < m_prio[2*win +: 2])) win = s;
                if (win >= 0) begin
                    clr[win] = 1; n_cur = win; n_step = 0; n_state = 1;
                end
            end else if (m_state == 1) begin
                n_state = 2;
            end else if (conv_done) begin
                m_res[m_cur] = 32'(conv_data);
                nib = m_ctl[m_cur][4*m_step +: 4];
                if (nib[2]) setb[m_cur] = 1;
                dep = (m_cur == 0) ? 8 : (m_cur == 3) ? 1 : 4;
                if (nib[1] || m_step == dep - 1) n_state = 0;
                else begin n_step = m_step + 1; n_state = 1; end
            end
            n_pend = ((m_pend & ~clr) | hit) & m_en;
            clrw = (wr_en && wr_addr == 8'h0C) ? wr_data[3:0] : 4'h0;
            m_raw = (m_raw & ~clrw) | setb;
            m_pend = n_pend;
            m_state = n_state; m_cur = n_cur; m_step = n_step;
            if (wr_en) begin
                case (wr_addr)
                    8'h00: m_en = wr_data[3:0];
                    8'h08: m_mask = wr_data[3:0];
                    8'h10: m_evsel = wr_data[15:0];
                    8'h14: m_prio = wr_data[7:0];
                    default: for (int s = 0; s < 4; s++) begin
                        if (wr_addr == 8'(32 + 16*s))     m_mux[s] = wr_data;
                        if (wr_addr == 8'(32 + 16*s + 4)) m_ctl[s] = wr_data;
                    end
                endcase
            end
        end
    end

    // Every-cycle comparison and converter start capture, mid-cycle.
    initial forever begin
        @(posedge clk);
        #5;
        if (rst_n) begin
            chk("R4 conv_start", 32'(conv_start), 32'(m_state == 1));
            if (m_state == 1) chk("R4 conv_chan", 32'(conv_chan), 32'(m_mux[m_cur][4*m_step +: 4]));
            chk("R11 irq", 32'(irq), 32'(m_raw & m_mask));
            chk(rtag(rd_addr), rd_data, mread(rd_addr));
            if (conv_start) begin
                chan_log.push_back(conv_chan);
                conv_last = conv_chan;
                conv_cnt = LAT;
            end
        end
    end

    // Converter model: done pulse LAT negedges after a start.
    always @(negedge clk) begin
        conv_done = 1'b0;
        if (conv_cnt > 0) begin
            conv_cnt--;
            if (conv_cnt == 0) begin
                conv_done = 1'b1;
                conv_data = {conv_last, 6'h2A};
            end
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic pulse(logic [NUM_EVT-1:0] m);
        @(negedge clk); evt_in = m;
        @(negedge clk); evt_in = '0;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk); rd_addr = rot_addr(rot); rot = (rot + 1) % 18;
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        @(negedge clk); rd_addr = a;
        @(posedge clk); #6; v = rd_data;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog (all requirements) act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        rd(8'h00, v); chk("R1 enable after reset", v, 0);
        rd(8'h04, v); chk("R1 raw after reset", v, 0);
        rd(8'h08, v); chk("R1 mask after reset", v, 0);
        rd(8'h14, v); chk("R1 priority after reset", v, 32'hE4);
        chk("R1 irq after reset", 32'(irq), 0);
        chk("R1 no start after reset", 32'(conv_start), 0);

        // R2: disabled sequencers ignore events, config writable
        wr(8'h10, 32'h3210);
        wr(8'h30, 32'h0000_5432);
        wr(8'h34, 32'h0);
        wr(8'h20, 32'hFEDC_BA98);
        chan_log.delete();
        pulse(4'hF); idle(30);
        chk("R2 disabled no start", chan_log.size(), 0);
        rd(8'h30, v); chk("R2 mux readback", v, 32'h0000_5432);

        // R4 R5 R9 R10 R11: END on step 2 with IE
        wr(8'h24, 32'h0000_0600);
        wr(8'h08, 32'h1);
        wr(8'h00, 32'h1);
        chan_log.delete();
        pulse(4'h1); idle(30);
        chk("R5 end-bit step count", chan_log.size(), 3);
        if (chan_log.size() == 3) begin
            chk("R4 step0 channel", chan_log[0], 8);
            chk("R4 step1 channel", chan_log[1], 9);
            chk("R4 step2 channel", chan_log[2], 10);
        end
        rd(8'h04, v); chk("R10 raw set by IE", v, 1);
        chk("R11 irq masked on", 32'(irq), 1);
        rd(8'h28, v); chk("R9 result of last step", v, {22'd0, 4'hA, 6'h2A});
        rd(8'h38, v); chk("R9 other result untouched", v, 0);
        wr(8'h0C, 32'h1); idle(2);
        rd(8'h04, v); chk("R10 raw cleared", v, 0);
        chk("R11 irq off after clear", 32'(irq), 0);

        // R6: physical depth limits
        wr(8'h24, 32'h0);
        wr(8'h50, 32'h0000_0001);
        wr(8'h00, 32'hB);
        chan_log.delete();
        pulse(4'h2); idle(30);
        chk("R6 seq1 depth", chan_log.size(), 4);
        if (chan_log.size() == 4) chk("R6 seq1 last channel", chan_log[3], 5);
        chan_log.delete();
        pulse(4'h8); idle(20);
        chk("R6 seq3 depth", chan_log.size(), 1);
        chan_log.delete();
        pulse(4'h1); idle(50);
        chk("R6 seq0 depth", chan_log.size(), 8);
        if (chan_log.size() == 8) chk("R6 seq0 last channel", chan_log[7], 15);

        // R7: priority order, reprogramming and tie-break
        wr(8'h00, 32'h3);
        wr(8'h24, 32'h2);
        wr(8'h34, 32'h2);
        chan_log.delete();
        pulse(4'h3); idle(20);
        chk("R7 default count", chan_log.size(), 2);
        if (chan_log.size() == 2) chk("R7 default seq0 first", chan_log[0], 8);
        wr(8'h14, 32'hA3);
        chan_log.delete();
        pulse(4'h3); idle(20);
        if (chan_log.size() == 2) chk("R7 reprogrammed seq1 first", chan_log[0], 2);
        else chk("R7 reprogrammed count", chan_log.size(), 2);
        wr(8'h14, 32'h00);
        chan_log.delete();
        pulse(4'h3); idle(20);
        if (chan_log.size() == 2) chk("R7 tie lower index first", chan_log[0], 8);
        else chk("R7 tie count", chan_log.size(), 2);

        // R8: no preemption, busy-time events kept
        wr(8'h14, 32'hE1);
        wr(8'h24, 32'h0);
        chan_log.delete();
        pulse(4'h1); idle(5);
        pulse(4'h3); idle(100);
        chk("R8 total starts", chan_log.size(), 17);
        if (chan_log.size() == 17) begin
            chk("R8 running seq0 finished", chan_log[7], 15);
            chk("R8 seq1 served next", chan_log[8], 2);
            chk("R8 seq0 repeat served", chan_log[9], 8);
        end

        // R3: event select, out-of-range value
        wr(8'h00, 32'h1);
        wr(8'h24, 32'h2);
        wr(8'h10, 32'h3217);
        chan_log.delete();
        pulse(4'hF); idle(20);
        chk("R3 out-of-range select", chan_log.size(), 0);
        wr(8'h10, 32'h3212);
        chan_log.delete();
        pulse(4'h1); idle(20);
        chk("R3 unselected line", chan_log.size(), 0);
        pulse(4'h4); idle(20);
        chk("R3 selected line", chan_log.size(), 1);

        finished = 1;
        summary();
        $finish;
    end
endmodule